// File: doc/BRIEF.md
# Byte-Stuffed Frame Transmitter with CRC-8

This block turns a payload held in a local byte store into a framed byte stream. The stream goes to a UART transmitter over a valid/ready byte handshake. Software-side logic first fills the store through a simple write port. It then pulses `start` together with a byte count. The block emits the frame in this order: an opening flag 0x7E, the payload bytes, one CRC-8 byte, and a closing flag 0x7E. Payload bytes and the CRC byte that collide with the flag or escape codes are stuffed.

The CRC is a reflected CRC-8 with polynomial 0x8C, preset to 0xFF. It is accumulated over the original, unstuffed payload bytes. The resulting CRC byte then passes through the same stuffing path as the data. Every stuffed byte costs one extra slot on the output. `busy` tells the requester when a new frame may be launched.

Top module: `sft_frame_tx`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `tx_valid` are both 0.
- R2: A frame is a 0x7E flag, then the stuffed payload in address order from 0, then the stuffed CRC byte, then a 0x7E flag. No unstuffed 0x7E appears between the two flags.
- R3: A byte of value 0x7E goes out as 0x7D, 0x5E, and a byte of value 0x7D goes out as 0x7D, 0x5D (the byte XOR 0x20 after a 0x7D prefix). Every other value goes out unchanged in one slot.
- R4: The CRC byte is the reflected CRC-8 (polynomial 0x8C, shifted right one bit at a time, preset 0xFF, no final inversion) over the unstuffed payload bytes. For example, the payload 01 00 00 01 yields the wire sequence 7E 01 00 00 01 3A 7E.
- R5: The CRC byte is stuffed by the same rule as payload bytes.
- R6: A byte transfers on a rising clock edge where `tx_valid` and `tx_ready` are both 1. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_data` hold their values.
- R7: `busy` rises in the cycle after a start is taken. It stays 1 until the closing flag has transferred and is 0 in the following cycle. `tx_valid` is 1 only while `busy` is 1.
- R8: A start pulse while `busy` is 1 is ignored. The frame in flight is unchanged, and no second frame follows it.
- R9: A length of 0 sends the frame 7E FF 7E.
- R10: A length greater than `DEPTH` (64 by default) is treated as `DEPTH`.
- R11: The payload position and the remaining count advance only when the second byte of a stuffed pair, or an unstuffed byte, transfers. They do not advance when the 0x7D prefix transfers.
- R12: When `wr_en` is 1 on a clock edge, `wr_data` is stored at store address `wr_addr`. Payload byte k of the next frame is read from address k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Payload store write strobe |
| wr_addr | input | ADDR_W (6) | Payload store write address |
| wr_data | input | 8 | Payload store write byte |
| start | input | 1 | Begin a frame (taken only when idle) |
| start_len | input | LEN_W (7) | Payload byte count for the frame |
| tx_valid | output | 1 | Output byte is valid |
| tx_data | output | 8 | Output byte toward the UART |
| tx_ready | input | 1 | UART accepts the byte |
| busy | output | 1 | A frame is in progress |

## Verification
Two events can coincide in one cycle. A stuffed byte is in mid-pair at the moment a back-pressure stall begins. Likewise, a new start request can arrive while the frame is still in flight, including during stuffed pairs. The bench provokes the first by running frames full of 0x7E/0x7D bytes under several irregular `tx_ready` patterns, including one that stalls two cycles out of three. It provokes the second by pulsing `start` with a different length a few cycles into a frame. Each captured wire sequence is judged byte for byte against a frame built arithmetically in the bench. The bench also checks that the block returns to idle with no second frame after the closing flag.

// File: rtl/sft_pkg.sv
// Shared constants and state encoding for the byte-stuffed frame transmitter.
// Assumes 8-bit bytes and the reflected CRC-8 form (right-shifting).
package sft_pkg;

    localparam logic [7:0] FLAG_BYTE   = 8'h7E;
    localparam logic [7:0] ESC_BYTE    = 8'h7D;
    localparam logic [7:0] FLIP_MASK   = 8'h20;
    localparam logic [7:0] CRC_POLY    = 8'h8C;
    localparam logic [7:0] CRC_PRESET  = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPEN  = 3'd1,
        ST_BODY  = 3'd2,
        ST_CSUM  = 3'd3,
        ST_CLOSE = 3'd4
    } sft_state_t;

endpackage

// File: rtl/sft_payload_store.sv
// Payload byte store: one synchronous write port, one combinational read port.
// Assumes the requester does not rewrite bytes of a frame while it is sent.
module sft_payload_store #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem_q [DEPTH];

    // Store a byte on each write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Present the addressed byte without delay.
    always_comb begin
        rd_data = mem_q[rd_addr];
    end

endmodule

// File: rtl/sft_crc8_step.sv
// One-byte update of a reflected CRC-8. The byte is folded into the low end
// and eight right shifts are applied, each XORing POLY when bit 0 was set.
// Assumes the caller holds the running value in a register.
module sft_crc8_step #(
    parameter logic [7:0] POLY = 8'h8C
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);

    logic [7:0] stage [9];

    assign stage[0] = crc_in ^ data_in;

    genvar g;
    generate
        for (g = 0; g < 8; g++) begin : g_shift
            // One bit of the right-shifting division.
            always_comb begin
                stage[g+1] = (stage[g] >> 1) ^ (stage[g][0] ? POLY : 8'h00);
            end
        end
    endgenerate

    assign crc_out = stage[8];

endmodule

// File: rtl/sft_stuffer.sv
// Byte-stuffing selector. Given a raw byte and whether its prefix has already
// been sent, picks the wire byte and tells whether the raw byte is finished.
// Assumes the caller keeps the raw byte steady across the two slots of a pair.
module sft_stuffer
    import sft_pkg::*;
(
    input  logic [7:0] raw_byte,
    input  logic       prefix_sent,
    output logic [7:0] wire_byte,
    output logic       byte_done
);

    logic special;

    // Classify the raw byte and choose what goes on the wire.
    always_comb begin
        special = (raw_byte == FLAG_BYTE) || (raw_byte == ESC_BYTE);
        if (prefix_sent) begin
            wire_byte = raw_byte ^ FLIP_MASK;
            byte_done = 1'b1;
        end else if (special) begin
            wire_byte = ESC_BYTE;
            byte_done = 1'b0;
        end else begin
            wire_byte = raw_byte;
            byte_done = 1'b1;
        end
    end

endmodule

// File: rtl/sft_frame_tx.sv
// Frame transmitter top. Sends flag, stuffed payload, stuffed CRC-8 and flag
// over a valid/ready byte port. Starts are taken only while idle; lengths
// above DEPTH are clamped. Synchronous active-low reset.
module sft_frame_tx
    import sft_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              busy
);

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);

    sft_state_t        state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [LEN_W-1:0]  remaining_q;
    logic [7:0]        crc_q;
    logic              prefix_q;

    logic [7:0]        store_byte;
    logic [7:0]        raw_byte;
    logic [7:0]        stuffed_byte;
    logic              byte_done;
    logic [7:0]        crc_next;
    logic [LEN_W-1:0]  len_eff;
    logic              fire;

    sft_payload_store #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (ptr_q),
        .rd_data (store_byte)
    );

    sft_crc8_step #(
        .POLY (CRC_POLY)
    ) u_crc (
        .crc_in  (crc_q),
        .data_in (store_byte),
        .crc_out (crc_next)
    );

    sft_stuffer u_stuff (
        .raw_byte    (raw_byte),
        .prefix_sent (prefix_q),
        .wire_byte   (stuffed_byte),
        .byte_done   (byte_done)
    );

    // Clamp the requested length to the store depth.
    always_comb begin
        len_eff = (start_len > MAX_LEN) ? MAX_LEN : start_len;
    end

    // Pick the raw byte feeding the stuffer: payload or CRC.
    always_comb begin
        raw_byte = (state_q == ST_CSUM) ? crc_q : store_byte;
    end

    // Drive the output port from the current state.
    always_comb begin
        tx_valid = (state_q != ST_IDLE);
        busy     = (state_q != ST_IDLE);
        case (state_q)
            ST_OPEN, ST_CLOSE: tx_data = FLAG_BYTE;
            ST_BODY, ST_CSUM:  tx_data = stuffed_byte;
            default:           tx_data = 8'h00;
        endcase
        fire = tx_valid && tx_ready;
    end

    // Frame sequencer: advance on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ptr_q       <= '0;
            remaining_q <= '0;
            crc_q       <= CRC_PRESET;
            prefix_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        remaining_q <= len_eff;
                        ptr_q       <= '0;
                        crc_q       <= CRC_PRESET;
                        prefix_q    <= 1'b0;
                        state_q     <= ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (fire) begin
                        state_q <= (remaining_q == '0) ? ST_CSUM : ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (fire) begin
                        if (!byte_done) begin
                            prefix_q <= 1'b1;
                        end else begin
                            prefix_q    <= 1'b0;
                            crc_q       <= crc_next;
                            ptr_q       <= ptr_q + 1'b1;
                            remaining_q <= remaining_q - ONE_LEN;
                            if (remaining_q == ONE_LEN) begin
                                state_q <= ST_CSUM;
                            end
                        end
                    end
                end
                ST_CSUM: begin
                    if (fire) begin
                        if (!byte_done) begin
                            prefix_q <= 1'b1;
                        end else begin
                            prefix_q <= 1'b0;
                            state_q  <= ST_CLOSE;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (fire) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sft_frame_tx_checker.sv
// Temporal checks on the frame transmitter, bound into every instance.
// Observes ports plus the position, count and CRC registers.
module sft_frame_tx_checker #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int LEN_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic [ADDR_W-1:0] ptr_q,
    input logic [LEN_W-1:0]  remaining_q,
    input logic [7:0]        crc_q
);

    logic fire;
    assign fire = tx_valid && tx_ready;

    assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_valid_within_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    assert_idle_after_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(fire) && ($past(tx_data) == 8'h7E)));

    assert_pair_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && tx_data == 8'h7D) |=> (tx_valid && (tx_data == 8'h5E || tx_data == 8'h5D)));

    assert_prefix_no_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && tx_data == 8'h7D) |=> ($stable(ptr_q) && $stable(remaining_q)));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !fire) |=> ($stable(remaining_q) && $stable(ptr_q)));

    assert_crc_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (crc_q == 8'hFF && $past(start)));

endmodule

bind sft_frame_tx sft_frame_tx_checker #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .ptr_q       (ptr_q),
    .remaining_q (remaining_q),
    .crc_q       (crc_q)
);

// File: tb/sft_frame_tx_test.sv
// Self-checking bench: sweeps byte values and lengths under several
// back-pressure patterns, comparing each wire frame with a bench-built one.
module sft_frame_tx_test;

    localparam int DEPTH  = 64;
    localparam int ADDR_W = 6;
    localparam int LEN_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  start_len = '0;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b0;
    logic              busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] pay [DEPTH];
    logic [7:0] exp_b [200];
    logic [7:0] got_b [200];
    int exp_n;
    int got_n;

    sft_frame_tx #(.DEPTH(DEPTH)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .start     (start),
        .start_len (start_len),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .busy      (busy)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] x = c ^ b;
        for (int k = 0; k < 8; k++) x = x[0] ? ((x >> 1) ^ 8'h8C) : (x >> 1);
        return x;
    endfunction

    task automatic push_stuffed(input logic [7:0] b);
        if (b == 8'h7E || b == 8'h7D) begin
            exp_b[exp_n] = 8'h7D; exp_n++;
            exp_b[exp_n] = b ^ 8'h20; exp_n++;
        end else begin
            exp_b[exp_n] = b; exp_n++;
        end
    endtask

    task automatic build_expected(input int n);
        logic [7:0] c = 8'hFF;
        exp_n = 0;
        exp_b[exp_n] = 8'h7E; exp_n++;
        for (int i = 0; i < n; i++) begin
            push_stuffed(pay[i]);
            c = crc_upd(c, pay[i]);
        end
        push_stuffed(c);
        exp_b[exp_n] = 8'h7E; exp_n++;
    endtask

    task automatic load_payload(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = ADDR_W'(i); wr_data = pay[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_start(input int len);
        @(negedge clk);
        start = 1'b1; start_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Collect one frame; mode selects the ready pattern, inject_at pulses start.
    task automatic run_frame(input int mode, input int inject_at);
        int cyc = 0;
        bit done = 0;
        got_n = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            start = (cyc == inject_at);
            start_len = LEN_W'(3);
            case (mode)
                0: tx_ready = 1'b1;
                1: tx_ready = ((cyc * 3 + 1) % 4) != 0;
                2: tx_ready = (cyc % 3) == 0;
                default: tx_ready = ((cyc * 5) % 7) > 2;
            endcase
            #1;
            if (tx_valid && !busy) check(0, "R7", busy, 1);
            if (tx_valid && tx_ready) begin
                got_b[got_n] = tx_data;
                got_n++;
                if (got_n > 1 && tx_data == 8'h7E) done = 1;
            end
            cyc++;
        end
        @(negedge clk);
        start = 1'b0; tx_ready = 1'b0;
        #1;
        check(!busy && !tx_valid, "R7/R8 idle after frame", {busy, tx_valid}, 0);
    endtask

    task automatic compare_frame(input string req);
        bit ok = (got_n == exp_n);
        int bad = -1;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (got_b[i] !== exp_b[i] && bad < 0) bad = i;
        if (bad >= 0) ok = 0;
        if (!ok && bad >= 0) check(0, req, got_b[bad], exp_b[bad]);
        else check(ok, req, got_n, exp_n);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1600000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] lit [7];
        int crc_b;
        repeat (3) @(negedge clk);
        #1;
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(busy == 1'b0 && tx_valid == 1'b0, "R1 idle after reset", {busy, tx_valid}, 0);

        // R4 worked example, compared with literal bytes.
        pay[0] = 8'h01; pay[1] = 8'h00; pay[2] = 8'h00; pay[3] = 8'h01;
        load_payload(4);
        do_start(4);
        run_frame(0, -1);
        lit = '{8'h7E, 8'h01, 8'h00, 8'h00, 8'h01, 8'h3A, 8'h7E};
        check(got_n == 7, "R4 example length", got_n, 7);
        for (int i = 0; i < 7; i++)
            check(got_b[i] == lit[i], "R4 example byte", got_b[i], lit[i]);

        // R9 empty frame.
        do_start(0);
        run_frame(1, -1);
        check(got_n == 3 && got_b[0] == 8'h7E && got_b[1] == 8'hFF && got_b[2] == 8'h7E,
              "R9 empty frame", got_b[1], 8'hFF);

        // R3 and R11: consecutive stuffed bytes under heavy stalls.
        pay[0] = 8'h7E; pay[1] = 8'h7D; pay[2] = 8'h7E; pay[3] = 8'h7D; pay[4] = 8'h00;
        load_payload(5);
        do_start(5);
        run_frame(2, -1);
        build_expected(5);
        compare_frame("R3/R11 stuffed run");
        check(got_b[1] == 8'h7D && got_b[2] == 8'h5E && got_b[4] == 8'h5D,
              "R3 stuffed values", got_b[2], 8'h5E);

        // R5: a single byte whose CRC collides with a special code.
        crc_b = -1;
        for (int b = 0; b < 256 && crc_b < 0; b++)
            if (crc_upd(8'hFF, 8'(b)) == 8'h7E || crc_upd(8'hFF, 8'(b)) == 8'h7D) crc_b = b;
        pay[0] = 8'(crc_b);
        load_payload(1);
        do_start(1);
        run_frame(3, -1);
        build_expected(1);
        compare_frame("R5 stuffed CRC");

        // R2/R4: every single-byte value.
        for (int b = 0; b < 256; b++) begin
            pay[0] = 8'(b);
            load_payload(1);
            do_start(1);
            run_frame(b % 4, -1);
            build_expected(1);
            compare_frame("R2/R4 byte sweep");
        end

        // R2/R12: every length with a changing pattern.
        for (int n = 0; n <= DEPTH; n++) begin
            for (int i = 0; i < DEPTH; i++) pay[i] = 8'((i * 37 + n * 11) % 256);
            load_payload(DEPTH);
            do_start(n);
            run_frame(n % 4, -1);
            build_expected(n);
            compare_frame("R2/R12 length sweep");
        end

        // R10: oversize length is clamped.
        do_start(100);
        run_frame(1, -1);
        build_expected(DEPTH);
        compare_frame("R10 clamp");

        // R8: start pulse mid-frame is ignored.
        do_start(10);
        run_frame(2, 2);
        build_expected(10);
        compare_frame("R8 start while busy");

        // R6/R7: stall on the closing flag.
        pay[0] = 8'h55;
        load_payload(1);
        do_start(1);
        tx_ready = 1'b1;
        repeat (3) @(negedge clk);
        tx_ready = 1'b0;
        for (int k = 0; k < 5; k++) begin
            #1;
            check(busy && tx_valid && tx_data == 8'h7E, "R6/R7 held closing flag", tx_data, 8'h7E);
            @(negedge clk);
        end
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        #1;
        check(!busy, "R7 busy falls after flag", busy, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule